// File: doc/BRIEF.md
# Prioritized Interrupt Resolver with Promotion

This block takes every interrupt request a small microcontroller core can see and turns them into one answer per cycle: whether any request may be taken now, and which one. The requests are an external reset pin, two fault detectors (clock monitor and watchdog), an illegal-opcode trap, a software trap, two active-low external request pins (a non-maskable one and a maskable one) and a parameterised set of on-chip peripheral requests, 14 by default. The core feeds in its maskable-interrupt disable bit. The block owns the sticky non-maskable pin mask and a promotion register that moves one maskable source to the head of the maskable group.

The three external pins pass through a synchronizer. The maskable pin can be set to level or falling-edge sensitivity. In edge mode the block keeps a pending flag until the core acknowledges it. The result is registered, so the core sees the winning source index one clock after the qualified requests settle.

Top module: `intr_resolver`

## Requirements
- R1: Among the five unmaskable sources, the lower index always wins. The indices are reset pin = 0, clock-monitor fault = 1, watchdog fault = 2, illegal opcode = 3, software trap = 4. Any of them beats every other source.
- R2: Sources 0 to 4 are reported whatever the values of `mask_i` and `x_mask`.
- R3: The non-maskable pin (index 5) is reported only while `x_mask` is 0. `x_mask` is 1 after reset.
- R4: A write on `x_wr` with `x_wr_val` = 0 clears `x_mask` from the next cycle on. A write with `x_wr_val` = 1 is ignored, so `x_mask` never returns to 1 except through reset.
- R5: While `mask_i` = 1, no maskable source (index 6 and above) is reported, even when no other request is present.
- R6: Peripheral k (index 7+k) counts only when `periph_en[k]` = 1. The maskable pin (index 6) has no local enable.
- R7: Without promotion, maskable sources rank by index: the maskable pin (6) first, then peripherals 0 to 13 (indices 7 to 20).
- R8: Promotion slot p promotes source index 6+p (slot 0 = maskable pin, slot k+1 = peripheral k). The promoted source beats every other maskable source but still ranks below index 5.
- R9: A write on `promo_wr` loads `promo_val` only when `mask_i` = 1 and `promo_val` is at most 14. Other writes are ignored. The slot is 0 after reset.
- R10: In level mode (`irq_edge_mode` = 0), a low maskable pin is reported on the third clock edge after it falls and stays reported while the pin is low.
- R11: In edge mode, a falling edge on the maskable pin is reported from the third edge on and stays pending after the pin rises, until `irq_ack` clears it. A pin held low after the acknowledge does not request again.
- R12: `req_valid` and `req_index` are registered one cycle after their direct inputs. With no request, `req_valid` = 0 and `req_index` = 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pad_reset_n | input | 1 | External reset request pin, active low, level |
| fault_clkmon | input | 1 | Clock-monitor fault request |
| fault_cop | input | 1 | Watchdog fault request |
| illegal_op | input | 1 | Illegal-opcode trap request |
| swi_req | input | 1 | Software trap request |
| pad_xirq_n | input | 1 | Non-maskable request pin, active low, level |
| pad_irq_n | input | 1 | Maskable request pin, active low |
| irq_edge_mode | input | 1 | 1 = falling-edge sensitivity for the maskable pin |
| irq_ack | input | 1 | Clears the latched edge-mode pending flag |
| periph_req | input | N_PERIPH | On-chip peripheral requests |
| periph_en | input | N_PERIPH | Local enables, one per peripheral |
| mask_i | input | 1 | Core maskable-interrupt disable bit |
| x_wr | input | 1 | Write strobe for the non-maskable pin mask |
| x_wr_val | input | 1 | Value written with `x_wr` |
| promo_wr | input | 1 | Write strobe for the promotion slot |
| promo_val | input | PW | Promotion slot to write |
| x_mask | output | 1 | Current non-maskable pin mask |
| req_valid | output | 1 | A request may be taken |
| req_index | output | IDX_W | Index of the winning source, 31 when idle |

## Verification
The held state sits in three places: the sticky pin mask, the promotion slot and the edge pending flag. A fault in the pin mask shows on `x_mask` in the cycle after the write, and on whether index 5 wins in the cycle after that. A wrong promotion slot only shows when two maskable sources compete, so the bench mixes random peripheral patterns with a bench-side model of the slot across thousands of cycles. A pending flag that is lost or never cleared shows three edges after the pin falls, or two edges after the acknowledge.

// File: rtl/intr_pkg.sv
package intr_pkg;
   // Fixed source ranks; the winning index reported is the rank itself.
   localparam int SRC_RESET   = 0;
   localparam int SRC_CLKMON  = 1;
   localparam int SRC_COP     = 2;
   localparam int SRC_ILLOP   = 3;
   localparam int SRC_SWI     = 4;
   localparam int SRC_XIRQ    = 5;
   localparam int SRC_IRQ     = 6;
   localparam int SRC_PERIPH0 = 7;
endpackage

// File: rtl/intr_pad_cond.sv
module intr_pad_cond #(
   parameter int STAGES       = 2,
   parameter bit EDGE_CAPABLE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pad_n,
   input  logic edge_mode,
   input  logic ack,
   output logic active
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("intr_pad_cond: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh;
   logic              synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-2:0], pad_n};
   end
   assign synced = sh[STAGES-1];

   generate
      if (EDGE_CAPABLE) begin : g_edge
         logic prev, pend, fall;
         assign fall = prev & ~synced;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev <= 1'b1;
               pend <= 1'b0;
            end else begin
               prev <= synced;
               pend <= edge_mode & (fall | (pend & ~ack));
            end
         end
         assign active = edge_mode ? (pend | fall) : ~synced;

         assert_pend_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_mode && pend && !ack) |=> pend);
      end else begin : g_level
         logic unused_cfg;
         assign unused_cfg = edge_mode ^ ack;
         assign active     = ~synced;
      end
   endgenerate
endmodule

// File: rtl/intr_mask_regs.sv
module intr_mask_regs #(
   parameter int N_MASKABLE = 15,
   parameter int PW         = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mask_i,
   input  logic          x_wr,
   input  logic          x_wr_val,
   input  logic          promo_wr,
   input  logic [PW-1:0] promo_val,
   output logic          x_q,
   output logic [PW-1:0] promo_q
);
   generate
      if (N_MASKABLE > (1 << PW)) begin : g_bad_pw
         $error("intr_mask_regs: PW too narrow for N_MASKABLE");
      end
   endgenerate

   logic promo_ok;
   assign promo_ok = promo_wr & mask_i & (int'(promo_val) < N_MASKABLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q     <= 1'b1;
         promo_q <= '0;
      end else begin
         if (x_wr && !x_wr_val) x_q <= 1'b0;
         if (promo_ok)          promo_q <= promo_val;
      end
   end

   assert_x_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !x_q |=> !x_q);
   assert_promo_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_i |=> $stable(promo_q));
endmodule

// File: rtl/intr_prio_pick.sv
module intr_prio_pick
   import intr_pkg::*;
#(
   parameter int N_SRC      = 21,
   parameter int N_MASKABLE = 15,
   parameter int IDX_W      = 5,
   parameter int PW         = 4
) (
   input  logic [N_SRC-1:0] elig,
   input  logic [PW-1:0]    promo,
   output logic             hit,
   output logic [IDX_W-1:0] idx
);
   logic             hi_hit, lo_hit, promo_hit;
   logic [IDX_W-1:0] hi_idx, lo_idx, promo_idx;

   always_comb begin
      hi_hit = 1'b0;
      hi_idx = '0;
      for (int i = SRC_IRQ - 1; i >= 0; i--) begin
         if (elig[i]) begin
            hi_hit = 1'b1;
            hi_idx = IDX_W'(i);
         end
      end
      lo_hit = 1'b0;
      lo_idx = '0;
      for (int i = N_SRC - 1; i >= SRC_IRQ; i--) begin
         if (elig[i]) begin
            lo_hit = 1'b1;
            lo_idx = IDX_W'(i);
         end
      end
      promo_hit = 1'b0;
      for (int i = 0; i < N_MASKABLE; i++) begin
         if (PW'(i) == promo && elig[SRC_IRQ + i]) promo_hit = 1'b1;
      end
      promo_idx = IDX_W'(SRC_IRQ) + IDX_W'(promo);
   end

   assign hit = hi_hit | lo_hit;
   assign idx = hi_hit ? hi_idx : (promo_hit ? promo_idx : lo_idx);
endmodule

// File: rtl/intr_resolver.sv
module intr_resolver
   import intr_pkg::*;
#(
   parameter int N_PERIPH         = 14,
   parameter int SYNC_STAGES      = 2,
   parameter bit IRQ_EDGE_CAPABLE = 1'b1,
   localparam int N_SRC      = SRC_PERIPH0 + N_PERIPH,
   localparam int N_MASKABLE = N_PERIPH + 1,
   localparam int IDX_W      = $clog2(N_SRC + 1),
   localparam int PW         = (N_MASKABLE > 1) ? $clog2(N_MASKABLE) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pad_reset_n,
   input  logic                fault_clkmon,
   input  logic                fault_cop,
   input  logic                illegal_op,
   input  logic                swi_req,
   input  logic                pad_xirq_n,
   input  logic                pad_irq_n,
   input  logic                irq_edge_mode,
   input  logic                irq_ack,
   input  logic [N_PERIPH-1:0] periph_req,
   input  logic [N_PERIPH-1:0] periph_en,
   input  logic                mask_i,
   input  logic                x_wr,
   input  logic                x_wr_val,
   input  logic                promo_wr,
   input  logic [PW-1:0]       promo_val,
   output logic                x_mask,
   output logic                req_valid,
   output logic [IDX_W-1:0]    req_index
);
   generate
      if (N_PERIPH < 1) begin : g_bad_periph
         $error("intr_resolver: N_PERIPH must be at least 1");
      end
   endgenerate

   localparam logic [IDX_W-1:0] IDLE_IDX = '1;

   logic             rst_act, xirq_act, irq_act;
   logic             x_q;
   logic [PW-1:0]    promo_q;
   logic [N_SRC-1:0] elig;
   logic             pick_hit;
   logic [IDX_W-1:0] pick_idx;

   intr_pad_cond #(.STAGES(SYNC_STAGES), .EDGE_CAPABLE(1'b0)) u_pad_reset (
      .clk(clk), .rst_n(rst_n), .pad_n(pad_reset_n),
      .edge_mode(1'b0), .ack(1'b0), .active(rst_act));

   intr_pad_cond #(.STAGES(SYNC_STAGES), .EDGE_CAPABLE(1'b0)) u_pad_xirq (
      .clk(clk), .rst_n(rst_n), .pad_n(pad_xirq_n),
      .edge_mode(1'b0), .ack(1'b0), .active(xirq_act));

   intr_pad_cond #(.STAGES(SYNC_STAGES), .EDGE_CAPABLE(IRQ_EDGE_CAPABLE)) u_pad_irq (
      .clk(clk), .rst_n(rst_n), .pad_n(pad_irq_n),
      .edge_mode(irq_edge_mode), .ack(irq_ack), .active(irq_act));

   intr_mask_regs #(.N_MASKABLE(N_MASKABLE), .PW(PW)) u_regs (
      .clk(clk), .rst_n(rst_n), .mask_i(mask_i),
      .x_wr(x_wr), .x_wr_val(x_wr_val),
      .promo_wr(promo_wr), .promo_val(promo_val),
      .x_q(x_q), .promo_q(promo_q));

   assign elig[SRC_RESET]  = rst_act;
   assign elig[SRC_CLKMON] = fault_clkmon;
   assign elig[SRC_COP]    = fault_cop;
   assign elig[SRC_ILLOP]  = illegal_op;
   assign elig[SRC_SWI]    = swi_req;
   assign elig[SRC_XIRQ]   = xirq_act & ~x_q;
   assign elig[SRC_IRQ]    = irq_act & ~mask_i;

   generate
      for (genvar k = 0; k < N_PERIPH; k++) begin : g_periph
         assign elig[SRC_PERIPH0 + k] = periph_req[k] & periph_en[k] & ~mask_i;
      end
   endgenerate

   intr_prio_pick #(.N_SRC(N_SRC), .N_MASKABLE(N_MASKABLE), .IDX_W(IDX_W), .PW(PW)) u_pick (
      .elig(elig), .promo(promo_q), .hit(pick_hit), .idx(pick_idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid <= 1'b0;
         req_index <= IDLE_IDX;
      end else begin
         req_valid <= pick_hit;
         req_index <= pick_hit ? pick_idx : IDLE_IDX;
      end
   end

   assign x_mask = x_q;

   assert_imask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mask_i |=> (!req_valid || req_index < IDX_W'(SRC_IRQ)));
   assert_xmask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      x_mask |=> !(req_valid && req_index == IDX_W'(SRC_XIRQ)));
endmodule

// File: tb/test_intr_resolver.sv
module test_intr_resolver;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        pad_reset_n, fault_clkmon, fault_cop, illegal_op, swi_req;
   logic        pad_xirq_n, pad_irq_n, irq_edge_mode, irq_ack;
   logic [13:0] periph_req, periph_en;
   logic        mask_i, x_wr, x_wr_val, promo_wr;
   logic [3:0]  promo_val;
   logic        x_mask, req_valid;
   logic [4:0]  req_index;

   int checks = 0;
   int fails  = 0;
   logic       x_m;
   logic [3:0] promo_m;

   always #(CLK_PERIOD / 2) clk = ~clk;

   intr_resolver i_intr_resolver (
      .clk(clk), .rst_n(rst_n), .pad_reset_n(pad_reset_n),
      .fault_clkmon(fault_clkmon), .fault_cop(fault_cop), .illegal_op(illegal_op),
      .swi_req(swi_req), .pad_xirq_n(pad_xirq_n), .pad_irq_n(pad_irq_n),
      .irq_edge_mode(irq_edge_mode), .irq_ack(irq_ack),
      .periph_req(periph_req), .periph_en(periph_en), .mask_i(mask_i),
      .x_wr(x_wr), .x_wr_val(x_wr_val), .promo_wr(promo_wr), .promo_val(promo_val),
      .x_mask(x_mask), .req_valid(req_valid), .req_index(req_index));

   // Model of the held state per R4 and R9
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_m     <= 1'b1;
         promo_m <= 4'd0;
      end else begin
         if (x_wr && !x_wr_val) x_m <= 1'b0;
         if (promo_wr && mask_i && promo_val <= 4'd14) promo_m <= promo_val;
      end
   end

   function automatic logic [5:0] ref_pick(input logic [4:0] hard, input logic xirq,
                                           input logic x, input logic irq, input logic i,
                                           input logic [13:0] req, input logic [13:0] en,
                                           input int promo);
      logic [5:0]  r;
      logic [14:0] m;
      r = {1'b0, 5'd31};
      for (int k = 4; k >= 0; k--) if (hard[k]) r = {1'b1, 5'(k)};
      if (hard != 5'd0) return r;
      if (xirq && !x) return {1'b1, 5'd5};
      if (i) return {1'b0, 5'd31};
      m = {req & en, irq};
      if (m[promo]) return {1'b1, 5'(6 + promo)};
      for (int k = 14; k >= 0; k--) if (m[k]) r = {1'b1, 5'(6 + k)};
      return r;
   endfunction

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      pad_reset_n = 1'b1; fault_clkmon = 1'b0; fault_cop = 1'b0; illegal_op = 1'b0;
      swi_req = 1'b0; pad_xirq_n = 1'b1; pad_irq_n = 1'b1; irq_ack = 1'b0;
      periph_req = '0; periph_en = '0; x_wr = 1'b0; x_wr_val = 1'b0;
      promo_wr = 1'b0; promo_val = '0;
   endtask

   function automatic logic [5:0] outv();
      return {req_valid, req_index};
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_2024));
      idle_inputs();
      irq_edge_mode = 1'b0;
      mask_i = 1'b1;
      rst_n = 1'b0;
      tick(3);
      chk("R12 reset idle", outv(), {1'b0, 5'd31});
      chk("R3 reset x_mask", x_mask, 1'b1);
      rst_n = 1'b1;
      tick(3);
      chk("R12 idle after reset", outv(), {1'b0, 5'd31});

      // R1 / R2: unmaskable order
      fault_clkmon = 1'b1; swi_req = 1'b1;
      tick(1);
      chk("R1 clkmon over swi", outv(), {1'b1, 5'd1});
      fault_clkmon = 1'b0; swi_req = 1'b0;
      fault_cop = 1'b1; illegal_op = 1'b1; periph_req = '1; periph_en = '1; mask_i = 1'b0;
      tick(1);
      chk("R1 cop over illop and maskables", outv(), {1'b1, 5'd2});
      fault_cop = 1'b0;
      tick(1);
      chk("R1 illegal opcode", outv(), {1'b1, 5'd3});
      illegal_op = 1'b0; swi_req = 1'b1; mask_i = 1'b1;
      tick(1);
      chk("R2 swi with I set", outv(), {1'b1, 5'd4});
      pad_reset_n = 1'b0;
      tick(3);
      chk("R1 reset pin wins", outv(), {1'b1, 5'd0});
      idle_inputs();
      tick(3);

      // R3 / R4: sticky X
      pad_xirq_n = 1'b0;
      tick(3);
      chk("R3 xirq masked by X", outv(), {1'b0, 5'd31});
      x_wr = 1'b1; x_wr_val = 1'b1;
      tick(1);
      x_wr = 1'b0;
      chk("R4 set X on already set", x_mask, 1'b1);
      x_wr = 1'b1; x_wr_val = 1'b0;
      tick(1);
      x_wr = 1'b0;
      chk("R4 X cleared", x_mask, 1'b0);
      tick(1);
      chk("R3 xirq reported", outv(), {1'b1, 5'd5});
      x_wr = 1'b1; x_wr_val = 1'b1;
      tick(1);
      x_wr = 1'b0;
      tick(1);
      chk("R4 X set ignored", x_mask, 1'b0);
      chk("R4 xirq still reported", outv(), {1'b1, 5'd5});
      pad_xirq_n = 1'b1;
      tick(3);

      // R5 / R6: masking
      mask_i = 1'b1; periph_req = 14'h0008; periph_en = 14'h0008;
      tick(1);
      chk("R5 I blocks peripheral", outv(), {1'b0, 5'd31});
      mask_i = 1'b0;
      tick(1);
      chk("R6 peripheral 3 enabled", outv(), {1'b1, 5'd10});
      periph_en = '0;
      tick(1);
      chk("R6 local enable off", outv(), {1'b0, 5'd31});
      pad_irq_n = 1'b0;
      tick(3);
      chk("R6 irq has no local enable", outv(), {1'b1, 5'd6});
      mask_i = 1'b1;
      tick(1);
      chk("R5 I blocks irq", outv(), {1'b0, 5'd31});
      pad_irq_n = 1'b1; mask_i = 1'b0;
      tick(3);

      // R7: maskable order
      periph_req = 14'h2001; periph_en = '1;
      tick(1);
      chk("R7 peripheral 0 over 13", outv(), {1'b1, 5'd7});
      periph_req = 14'h2100;
      tick(1);
      chk("R7 peripheral 8 over 13", outv(), {1'b1, 5'd15});

      // R8 / R9: promotion
      periph_req = 14'h0021;
      promo_wr = 1'b1; promo_val = 4'd6;
      tick(1);
      promo_wr = 1'b0;
      tick(1);
      chk("R9 write with I clear ignored", outv(), {1'b1, 5'd7});
      mask_i = 1'b1; promo_wr = 1'b1; promo_val = 4'd6;
      tick(1);
      promo_wr = 1'b0; mask_i = 1'b0;
      tick(1);
      chk("R8 promoted slot 6 wins", outv(), {1'b1, 5'd12});
      mask_i = 1'b1; promo_wr = 1'b1; promo_val = 4'd15;
      tick(1);
      promo_wr = 1'b0; mask_i = 1'b0;
      tick(1);
      chk("R9 out of range ignored", outv(), {1'b1, 5'd12});
      pad_irq_n = 1'b0;
      tick(3);
      chk("R8 promoted over irq", outv(), {1'b1, 5'd12});
      pad_xirq_n = 1'b0;
      tick(3);
      chk("R8 xirq over promoted", outv(), {1'b1, 5'd5});
      idle_inputs();
      tick(3);

      // R10: level mode
      pad_irq_n = 1'b0;
      tick(2);
      chk("R10 not before third edge", outv(), {1'b0, 5'd31});
      tick(1);
      chk("R10 level reported", outv(), {1'b1, 5'd6});
      tick(4);
      chk("R10 held while low", outv(), {1'b1, 5'd6});
      pad_irq_n = 1'b1;
      tick(3);
      chk("R10 drops with pin", outv(), {1'b0, 5'd31});

      // R11: edge mode
      irq_edge_mode = 1'b1;
      tick(1);
      pad_irq_n = 1'b0;
      tick(3);
      chk("R11 edge reported", outv(), {1'b1, 5'd6});
      pad_irq_n = 1'b1;
      tick(3);
      chk("R11 pending after release", outv(), {1'b1, 5'd6});
      irq_ack = 1'b1;
      tick(1);
      irq_ack = 1'b0;
      tick(1);
      chk("R11 ack clears", outv(), {1'b0, 5'd31});
      pad_irq_n = 1'b0;
      tick(3);
      chk("R11 second edge", outv(), {1'b1, 5'd6});
      irq_ack = 1'b1;
      tick(1);
      irq_ack = 1'b0;
      tick(1);
      chk("R11 ack with pin low", outv(), {1'b0, 5'd31});
      tick(4);
      chk("R11 no refire while low", outv(), {1'b0, 5'd31});
      pad_irq_n = 1'b1;
      tick(3);
      pad_irq_n = 1'b0;
      tick(3);
      chk("R11 new edge refires", outv(), {1'b1, 5'd6});
      irq_ack = 1'b1;
      tick(1);
      irq_ack = 1'b0; pad_irq_n = 1'b1; irq_edge_mode = 1'b0;
      tick(4);

      // Random mix of direct sources, enables, I and register writes
      for (int n = 0; n < 2000; n++) begin
         logic [5:0] exp;
         fault_clkmon = ($urandom % 16) == 0;
         fault_cop    = ($urandom % 16) == 0;
         illegal_op   = ($urandom % 16) == 0;
         swi_req      = ($urandom % 16) == 0;
         periph_req   = 14'($urandom);
         periph_en    = 14'($urandom);
         mask_i       = 1'($urandom);
         x_wr         = ($urandom % 64) == 0;
         x_wr_val     = 1'($urandom);
         promo_wr     = ($urandom % 4) == 0;
         promo_val    = 4'($urandom);
         exp = ref_pick({swi_req, illegal_op, fault_cop, fault_clkmon, 1'b0},
                        1'b0, x_m, 1'b0, mask_i, periph_req, periph_en, int'(promo_m));
         tick(1);
         chk("R7 R8 R12 random pick", outv(), exp);
         chk("R4 random x_mask", x_mask, x_m);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule